// File: doc/BRIEF.md
# Multi-Lane Serial Master Transmit Engine

This block is the transmit half of a serial-peripheral master that can drive one, two or four data lines. Software writes a word into a single holding register. When the shift register is free, the word moves across on the next clock. The block then produces a serial clock for a programmed number of cycles and presents the word most significant bit first, one, two or four bits per serial clock. Once the word has moved out of the holding register, software may load the next one. If that word arrives before the final falling edge of the current word, it is shifted out without a pause.

Two status flags report progress: holding-register-empty and end-of-transmission. Both are cleared by writing one to them, and each has its own interrupt enable. A DMA request stays high while the block is enabled and the holding register is empty. A module-enable bit and a self-clearing soft-reset bit in the control register govern the whole engine. The serial clock idles low. Data lines change only on its falling edge and hold steady while it is high.

Register write port (byte-free, one word per write): address 0 control (bit 0 enable, bit 1 soft reset), address 1 configuration (bits 1:0 lane mode, bits 5:2 length L, bit 6 direction), address 2 transmit data, address 3 flag clear (bit 0 empty, bit 1 end), address 4 interrupt enable (bit 0 empty, bit 1 end).

Top module: `mlspi_tx`

## Requirements
- R1: After reset, sclk is 0, sd_out and sd_oe are 0, busy is 0, flag_empty is 1, flag_done is 0, irq is 0 and dma_req is 0 (module disabled).
- R2: A write to address 2 while enabled and idle makes busy 1 and flag_empty 1 one clock after the write is captured, and the holding register is free again (dma_req 1).
- R3: A word with length field L produces exactly L+1 serial clock pulses. Each high phase lasts CLK_HALF clock cycles.
- R4: Lane mode 0 sends one bit per pulse on sd_out[0]. Mode 1 sends two bits on sd_out[1:0], with sd_out[1] the more significant. Mode 2 sends four bits on sd_out[3:0]. Mode 3 behaves as mode 0. The bits sent are the low (L+1)×lanes bits of the written word, most significant first.
- R5: sd_out changes only at a falling edge of sclk or at the start of a word, and never while sclk stays high.
- R6: If the holding register is refilled before the last falling edge of a word, the next word starts at that edge, with busy staying 1 and no end flag set.
- R7: If the holding register is empty at the last falling edge, sclk stays low, busy drops and flag_done is set.
- R8: Writing 1 to a bit at address 3 clears that flag and leaves the other flag alone. A transmit data write clears flag_empty. A flag set in the same cycle as its clear is kept.
- R9: irq is 1 whenever a flag is 1 and its enable bit at address 4 is 1, so enabling the empty interrupt right after reset raises irq at once.
- R10: dma_req is 1 exactly when the module is enabled and the holding register is empty.
- R11: sd_oe is 0001 in modes 0 and 3. In mode 1 it is 0011 and in mode 2 it is 1111 only while direction is 0, and 0000 when direction is 1. sd_oe is 0000 while disabled.
- R12: Clearing enable aborts a word in progress (busy 0, sclk 0), and transmit data writes while disabled are ignored.
- R13: Soft reset (control bit 1) empties the holding and shift registers, returns both flags to their reset values and keeps the configuration.
- R14: A second data write before the word has moved replaces the pending word, and only the later word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| sclk | output | 1 | Serial clock, idles low |
| sd_out | output | 4 | Serial data lines, line 3 most significant |
| sd_oe | output | 4 | Per-line output enable |
| busy | output | 1 | A word is being shifted |
| flag_empty | output | 1 | Holding-register-empty flag |
| flag_done | output | 1 | End-of-transmission flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request for the next word |

## Verification
The hardest case to reach is a refill that lands in the clock cycle just before the final falling edge. There the move into the shift register and the end decision happen on the same edge. The stimulus reaches it by counting serial clock rises from the bench. It issues the next data write at the clock sample where the last rise is first seen, so the write is captured one cycle ahead of the falling edge. The number of busy drops over the two words must then be one. A scoreboard, fed per pulse with the expected lane values, catches any lost or repeated word in this case as well as in the overwrite and streaming cases.

// File: rtl/mlspi_tx_pkg.sv
package mlspi_tx_pkg;

    localparam int LEN_W     = 4;
    localparam int LANES_MAX = 4;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2,
        LANE_XR = 2'd3
    } lane_mode_e;

    // configuration word: [6] direction, [5:2] length, [1:0] mode
    typedef struct packed {
        logic             dir_in;
        logic [LEN_W-1:0] len;
        lane_mode_e       mode;
    } word_cfg_t;

    typedef struct packed {
        logic done;
        logic empty;
    } flag_t;

    localparam int CFG_W = $bits(word_cfg_t);

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CFG  = 3'd1;
    localparam logic [2:0] ADDR_TXD  = 3'd2;
    localparam logic [2:0] ADDR_FLAG = 3'd3;
    localparam logic [2:0] ADDR_IEN  = 3'd4;

    function automatic logic [2:0] lane_count(input lane_mode_e m);
        case (m)
            LANE_X2: lane_count = 3'd2;
            LANE_X4: lane_count = 3'd4;
            default: lane_count = 3'd1;
        endcase
    endfunction

    function automatic logic [LANES_MAX-1:0] lane_mask(input lane_mode_e m);
        case (m)
            LANE_X2: lane_mask = 4'b0011;
            LANE_X4: lane_mask = 4'b1111;
            default: lane_mask = 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/mlspi_tx_regs.sv
module mlspi_tx_regs
    import mlspi_tx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              take,
    input  logic              word_done,
    output logic              mod_en,
    output logic              soft_rst,
    output word_cfg_t         cfg,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output flag_t             flags,
    output logic              irq,
    output logic              dma_req
);

    logic  wr_ctrl, wr_cfg, wr_txd, wr_flag, wr_ien;
    flag_t ien;

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_cfg   = reg_wr && (reg_addr == ADDR_CFG);
    assign wr_txd   = reg_wr && (reg_addr == ADDR_TXD) && mod_en;
    assign wr_flag  = reg_wr && (reg_addr == ADDR_FLAG);
    assign wr_ien   = reg_wr && (reg_addr == ADDR_IEN);
    assign soft_rst = wr_ctrl && reg_wdata[1];

    // configuration and enables survive a soft reset
    always_ff @(posedge clk) begin
        if (rst) begin
            mod_en <= 1'b0;
            cfg    <= '0;
            ien    <= '0;
        end else begin
            if (wr_ctrl) mod_en <= reg_wdata[0];
            if (wr_cfg)  cfg    <= word_cfg_t'(reg_wdata[CFG_W-1:0]);
            if (wr_ien)  ien    <= flag_t'(reg_wdata[1:0]);
        end
    end

    // holding register: a later write replaces a pending word
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_txd) begin
            hold_data <= reg_wdata;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // status flags: set events win over clears in the same cycle
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            flags.empty <= 1'b1;
            flags.done  <= 1'b0;
        end else begin
            if (take && !wr_txd)
                flags.empty <= 1'b1;
            else if (wr_txd)
                flags.empty <= 1'b0;
            else if (wr_flag && reg_wdata[0])
                flags.empty <= 1'b0;

            if (word_done)
                flags.done <= 1'b1;
            else if (wr_flag && reg_wdata[1])
                flags.done <= 1'b0;
        end
    end

    assign irq     = |(flags & ien);
    assign dma_req = mod_en && !hold_full;

endmodule

// File: rtl/mlspi_tx_sclk.sv
module mlspi_tx_sclk #(
    parameter int CLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic fall_tick
);

    localparam int             DIV_W   = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(CLK_HALF - 1);

    logic [DIV_W-1:0] div;
    logic             phase_end;

    assign phase_end = (div == DIV_TOP);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div  <= '0;
            sclk <= 1'b0;
        end else if (phase_end) begin
            div  <= '0;
            sclk <= ~sclk;
        end else begin
            div  <= div + 1'b1;
        end
    end

    // edge on which sclk goes from high to low
    assign fall_tick = run && sclk && phase_end;

endmodule

// File: rtl/mlspi_tx_shift.sv
module mlspi_tx_shift
    import mlspi_tx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst,
    input  logic                 mod_en,
    input  word_cfg_t            cfg,
    input  logic [DATA_W-1:0]    hold_data,
    input  logic                 hold_full,
    input  logic                 fall_tick,
    output logic                 busy,
    output logic                 take,
    output logic                 word_done,
    output logic [LANES_MAX-1:0] sd_out
);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] aligned;
    lane_mode_e        act_mode;
    logic [LEN_W-1:0]  act_len;
    logic [LEN_W-1:0]  cnt;
    logic              last;
    logic              halt;

    assign halt = soft_rst || !mod_en;
    assign last = (cnt == act_len);

    assign take      = !halt && hold_full && (!busy || (fall_tick && last));
    assign word_done = !halt && busy && fall_tick && last && !hold_full;

    // place the low (len+1)*lanes bits at the top of the shift register
    always_comb begin
        int nbits;
        nbits = (int'(cfg.len) + 1) * int'(lane_count(cfg.mode));
        if (nbits >= DATA_W)
            aligned = hold_data;
        else
            aligned = hold_data << (DATA_W - nbits);
    end

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            busy     <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            act_mode <= LANE_X1;
            act_len  <= '0;
        end else if (take) begin
            busy     <= 1'b1;
            shreg    <= aligned;
            cnt      <= '0;
            act_mode <= cfg.mode;
            act_len  <= cfg.len;
        end else if (busy && fall_tick) begin
            if (last) begin
                busy  <= 1'b0;
                shreg <= '0;
            end else begin
                shreg <= shreg << lane_count(act_mode);
                cnt   <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        sd_out = '0;
        if (busy) begin
            case (act_mode)
                LANE_X2: sd_out[1:0] = shreg[DATA_W-1 -: 2];
                LANE_X4: sd_out      = shreg[DATA_W-1 -: LANES_MAX];
                default: sd_out[0]   = shreg[DATA_W-1];
            endcase
        end
    end

endmodule

// File: rtl/mlspi_tx.sv
module mlspi_tx
    import mlspi_tx_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int CLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              sclk,
    output logic [3:0]        sd_out,
    output logic [3:0]        sd_oe,
    output logic              busy,
    output logic              flag_empty,
    output logic              flag_done,
    output logic              irq,
    output logic              dma_req
);

    logic              mod_en;
    logic              soft_rst;
    word_cfg_t         cfg;
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    flag_t             flags;
    logic              take;
    logic              word_done;
    logic              fall_tick;
    logic              run;

    mlspi_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .take      (take),
        .word_done (word_done),
        .mod_en    (mod_en),
        .soft_rst  (soft_rst),
        .cfg       (cfg),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .flags     (flags),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    mlspi_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .mod_en    (mod_en),
        .cfg       (cfg),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .fall_tick (fall_tick),
        .busy      (busy),
        .take      (take),
        .word_done (word_done),
        .sd_out    (sd_out)
    );

    assign run = busy && mod_en && !soft_rst;

    mlspi_tx_sclk #(.CLK_HALF(CLK_HALF)) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .sclk      (sclk),
        .fall_tick (fall_tick)
    );

    // multi-line modes drive only when direction selects output
    always_comb begin
        sd_oe = '0;
        if (mod_en) begin
            if (cfg.mode == LANE_X2 || cfg.mode == LANE_X4)
                sd_oe = cfg.dir_in ? '0 : lane_mask(cfg.mode);
            else
                sd_oe = lane_mask(LANE_X1);
        end
    end

    assign flag_empty = flags.empty;
    assign flag_done  = flags.done;

endmodule

// File: rtl/mlspi_tx_chk.sv
module mlspi_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       sclk,
    input logic [3:0] sd_out,
    input logic       busy,
    input logic       hold_full,
    input logic       mod_en,
    input logic       flag_done,
    input logic       dma_req
);

    // R3
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R5
    data_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sd_out));

    // R2
    start_from_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(hold_full));

    // R7
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_done) |-> (!busy && !sclk));

    // R12
    disable_stops_chk: assert property (@(posedge clk) disable iff (rst)
        !mod_en |=> !busy);

    // R10
    dma_only_empty_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> !hold_full);

endmodule

bind mlspi_tx mlspi_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .sd_out    (sd_out),
    .busy      (busy),
    .hold_full (hold_full),
    .mod_en    (mod_en),
    .flag_done (flag_done),
    .dma_req   (dma_req)
);

// File: tb/mlspi_tx_bench.sv
module mlspi_tx_bench;

    localparam int DW = 64;
    localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_TXD = 3'd2,
                           A_FLAG = 3'd3, A_IEN = 3'd4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          sclk, busy, flag_empty, flag_done, irq, dma_req;
    logic [3:0]    sd_out, sd_oe;

    always #10 clk = ~clk;

    mlspi_tx #(.DATA_W(DW), .CLK_HALF(2)) u_mlspi_tx (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe),
        .busy(busy), .flag_empty(flag_empty), .flag_done(flag_done),
        .irq(irq), .dma_req(dma_req)
    );

    int   checks = 0;
    int   fails = 0;
    int   rise_cnt = 0;
    int   busy_falls = 0;
    int   hi_len = 0;
    bit   sb_on = 1'b1;
    logic prev_sclk = 1'b0;
    logic prev_busy = 1'b0;
    logic [7:0] exp_q[$];

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver side: expected {oe, lanes} per serial clock pulse
    task automatic push_word(input logic [63:0] d, input logic [1:0] m,
                             input logic [3:0] len, input logic dr);
        int n;
        int nb;
        logic [3:0]  oe;
        logic [3:0]  msk;
        logic [63:0] t;
        n   = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
        msk = (m == 2'd1) ? 4'h3 : (m == 2'd2) ? 4'hF : 4'h1;
        oe  = (m == 2'd1) ? (dr ? 4'h0 : 4'h3) :
              (m == 2'd2) ? (dr ? 4'h0 : 4'hF) : 4'h1;
        nb  = (int'(len) + 1) * n;
        for (int k = 0; k <= int'(len); k++) begin
            t = d >> (nb - (k + 1) * n);
            exp_q.push_back({oe, t[3:0] & msk});
        end
    endtask

    // monitor: compare lanes at every observed rise of sclk
    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = 1'b0;
            prev_busy = 1'b0;
            hi_len    = 0;
        end else begin
            if (sclk && !prev_sclk) begin
                rise_cnt++;
                if (sb_on) begin
                    if (exp_q.size() == 0)
                        check_eq("R4", "unexpected pulse", 64'd1, 64'd0);
                    else
                        check_eq("R4", "lanes {oe,out}", {56'd0, sd_oe, sd_out},
                                 {56'd0, exp_q.pop_front()});
                end
            end
            if (sclk) hi_len++;
            else begin
                if (prev_sclk && sb_on)
                    check_eq("R3", "high phase cycles", 64'(hi_len), 64'd2);
                hi_len = 0;
            end
            if (prev_busy && !busy) busy_falls++;
            prev_sclk = sclk;
            prev_busy = busy;
        end
    end

    // called at a falling clock edge; write captured on the next rising edge
    task automatic wreg(input logic [2:0] a, input logic [63:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy && exp_q.size() == 0) break;
        end
        @(negedge clk);
    endtask

    task automatic wait_rises(input int n);
        int   seen;
        logic p;
        seen = 0;
        p    = sclk;
        while (seen < n) begin
            @(negedge clk);
            if (sclk && !p) seen++;
            p = sclk;
        end
    endtask

    function automatic logic [63:0] cfgw(input logic [1:0] m, input logic [3:0] l,
                                         input logic dr);
        return 64'({dr, l, m});
    endfunction

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        int b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "sclk", 64'(sclk), 0);
        check_eq("R1", "sd_out", 64'(sd_out), 0);
        check_eq("R1", "sd_oe", 64'(sd_oe), 0);
        check_eq("R1", "busy", 64'(busy), 0);
        check_eq("R1", "flag_empty", 64'(flag_empty), 1);
        check_eq("R1", "flag_done", 64'(flag_done), 0);
        check_eq("R1", "irq", 64'(irq), 0);
        check_eq("R1", "dma_req", 64'(dma_req), 0);

        wreg(A_CTRL, 64'h1);
        check_eq("R10", "dma_req enabled empty", 64'(dma_req), 1);
        wreg(A_IEN, 64'h1);
        check_eq("R9", "irq on empty enable", 64'(irq), 1);
        wreg(A_IEN, 64'h0);
        check_eq("R9", "irq masked", 64'(irq), 0);

        // single lane, start timing
        wreg(A_CFG, cfgw(2'd0, 4'd7, 1'b0));
        check_eq("R11", "oe single", 64'(sd_oe), 64'h1);
        push_word(64'hA5, 2'd0, 4'd7, 1'b0);
        r0 = rise_cnt;
        wreg(A_TXD, 64'hA5);
        check_eq("R8", "empty cleared by data write", 64'(flag_empty), 0);
        check_eq("R10", "dma_req low while full", 64'(dma_req), 0);
        @(negedge clk);
        check_eq("R2", "busy after move", 64'(busy), 1);
        check_eq("R2", "empty set on move", 64'(flag_empty), 1);
        check_eq("R2", "hold freed", 64'(dma_req), 1);
        wait_idle();
        check_eq("R3", "pulse count L=7", 64'(rise_cnt - r0), 8);
        check_eq("R7", "done flag", 64'(flag_done), 1);
        check_eq("R7", "sclk low", 64'(sclk), 0);
        check_eq("R7", "busy low", 64'(busy), 0);
        wreg(A_IEN, 64'h2);
        check_eq("R9", "irq on done", 64'(irq), 1);
        wreg(A_FLAG, 64'h2);
        check_eq("R8", "done cleared", 64'(flag_done), 0);
        check_eq("R8", "empty kept", 64'(flag_empty), 1);
        check_eq("R9", "irq after clear", 64'(irq), 0);

        // dual lane
        wreg(A_CFG, cfgw(2'd1, 4'd3, 1'b0));
        check_eq("R11", "oe dual", 64'(sd_oe), 64'h3);
        push_word(64'hB4, 2'd1, 4'd3, 1'b0);
        r0 = rise_cnt;
        wreg(A_TXD, 64'hB4);
        wait_idle();
        check_eq("R3", "pulse count dual", 64'(rise_cnt - r0), 4);

        // quad lane, full width
        wreg(A_CFG, cfgw(2'd2, 4'd15, 1'b0));
        check_eq("R11", "oe quad", 64'(sd_oe), 64'hF);
        push_word(64'h0123_4567_89AB_CDEF, 2'd2, 4'd15, 1'b0);
        r0 = rise_cnt;
        wreg(A_TXD, 64'h0123_4567_89AB_CDEF);
        wait_idle();
        check_eq("R3", "pulse count quad", 64'(rise_cnt - r0), 16);

        // reserved mode acts as single
        wreg(A_CFG, cfgw(2'd3, 4'd4, 1'b0));
        push_word(64'h15, 2'd3, 4'd4, 1'b0);
        wreg(A_TXD, 64'h15);
        wait_idle();
        check_eq("R4", "reserved mode queue drained", 64'(exp_q.size()), 0);

        // direction
        wreg(A_CFG, cfgw(2'd2, 4'd1, 1'b1));
        check_eq("R11", "oe quad input", 64'(sd_oe), 64'h0);
        push_word(64'h5A, 2'd2, 4'd1, 1'b1);
        wreg(A_TXD, 64'h5A);
        wait_idle();
        wreg(A_CFG, cfgw(2'd0, 4'd1, 1'b1));
        check_eq("R11", "oe single ignores dir", 64'(sd_oe), 64'h1);

        // early refill streaming
        wreg(A_CFG, cfgw(2'd1, 4'd3, 1'b0));
        wreg(A_FLAG, 64'h3);
        b0 = busy_falls;
        push_word(64'h96, 2'd1, 4'd3, 1'b0);
        push_word(64'h3E, 2'd1, 4'd3, 1'b0);
        wreg(A_TXD, 64'h96);
        @(negedge clk);
        wreg(A_TXD, 64'h3E);
        check_eq("R6", "no end flag mid-stream", 64'(flag_done), 0);
        wait_idle();
        check_eq("R6", "one busy drop early refill", 64'(busy_falls - b0), 1);
        check_eq("R7", "done after stream", 64'(flag_done), 1);

        // late refill: write captured one cycle before last falling edge
        wreg(A_FLAG, 64'h2);
        b0 = busy_falls;
        push_word(64'hC7, 2'd1, 4'd3, 1'b0);
        push_word(64'h28, 2'd1, 4'd3, 1'b0);
        wreg(A_TXD, 64'hC7);
        wait_rises(4);
        wreg(A_TXD, 64'h28);
        wait_idle();
        check_eq("R6", "one busy drop late refill", 64'(busy_falls - b0), 1);

        // overwrite of pending word
        wreg(A_CFG, cfgw(2'd0, 4'd7, 1'b0));
        b0 = busy_falls;
        push_word(64'h3C, 2'd0, 4'd7, 1'b0);
        push_word(64'hC3, 2'd0, 4'd7, 1'b0);
        wreg(A_TXD, 64'h3C);
        @(negedge clk);
        wreg(A_TXD, 64'h99);
        wreg(A_TXD, 64'hC3);
        wait_idle();
        check_eq("R14", "two words sent", 64'(busy_falls - b0), 1);
        check_eq("R14", "queue drained", 64'(exp_q.size()), 0);

        // disable aborts and blocks writes
        sb_on = 1'b0;
        wreg(A_TXD, 64'hFF);
        wait_rises(3);
        wreg(A_CTRL, 64'h0);
        @(negedge clk);
        check_eq("R12", "busy after disable", 64'(busy), 0);
        check_eq("R12", "sclk after disable", 64'(sclk), 0);
        check_eq("R11", "oe disabled", 64'(sd_oe), 0);
        check_eq("R10", "dma disabled", 64'(dma_req), 0);
        wreg(A_TXD, 64'h11);
        wreg(A_CTRL, 64'h1);
        repeat (6) @(negedge clk);
        check_eq("R12", "ignored write starts nothing", 64'(busy), 0);
        check_eq("R12", "hold still empty", 64'(dma_req), 1);

        // soft reset
        wreg(A_CFG, cfgw(2'd1, 4'd3, 1'b0));
        wreg(A_FLAG, 64'h3);
        wreg(A_TXD, 64'h77);
        @(negedge clk);
        wreg(A_TXD, 64'h44);
        wreg(A_CTRL, 64'h3);
        check_eq("R13", "busy cleared", 64'(busy), 0);
        check_eq("R13", "sclk low", 64'(sclk), 0);
        check_eq("R13", "empty reset value", 64'(flag_empty), 1);
        check_eq("R13", "done reset value", 64'(flag_done), 0);
        check_eq("R13", "hold dropped", 64'(dma_req), 1);
        repeat (4) @(negedge clk);
        check_eq("R13", "pending word dropped", 64'(busy), 0);
        sb_on = 1'b1;
        push_word(64'h6D, 2'd1, 4'd3, 1'b0);
        r0 = rise_cnt;
        wreg(A_TXD, 64'h6D);
        wait_idle();
        check_eq("R13", "config kept pulse count", 64'(rise_cnt - r0), 4);
        check_eq("R4", "final queue empty", 64'(exp_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule